// File: doc/BRIEF.md
# Snooping Four-State Cache Coherence Controller

This block keeps a single cached line coherent across three processors that share one bus and one main-memory word. Each processor owns a private one-line cache. Each cache tracks its copy as invalid, shared, exclusive or modified. It serves local reads and writes directly when the state allows it. Otherwise it asks for the bus and issues a read, a read-with-invalidate or a plain invalidate. The other caches watch every bus command and change their own copies to match.

A bus transaction has an address phase, an optional write-back phase and a completion phase. In the address phase the snooping caches report whether they hold a copy. A cache holding the line modified also raises a wait signal. It then writes its data to memory in the write-back phase, before the requester reads memory. Only one cache owns the bus at a time. When several ask in the same cycle, the lowest-numbered processor wins.

Each processor holds its request until `cpu_done` pulses for one cycle. At that pulse `cpu_rdata` carries the value read or written.

Top module: `mesi_coherence_top`

## Requirements
- R1: After reset every `line_state` field is 0, `mem_data` equals `MEM_INIT`, and `bus_grant`, `bus_cmd` and `cpu_done` are all zero. State codes on `line_state` are invalid=0, shared=1, exclusive=2, modified=3. Processor k (k=1..3) uses bits [2k-1:2k-2].
- R2: A read miss that finds no other valid copy returns the memory value and leaves the reader exclusive (2).
- R3: A read miss while another cache holds a clean copy raises `bus_shared`. Both copies end shared (1), and the reader gets the memory value.
- R4: A write to a shared line puts invalidate (`bus_cmd`=3) on the bus. Every other copy becomes invalid, and the writer ends modified with the written data.
- R5: A read miss while another cache holds the line modified raises `bus_wait`. The owner then raises `bus_wb` and copies its data into memory. Both caches end shared, and the reader returns the owner's data.
- R6: A write miss issues read-with-invalidate (`bus_cmd`=2). A modified owner writes back to memory first and becomes invalid. The writer ends modified with its own data.
- R7: A write hit on an exclusive or modified line, and any read hit, completes with no bus grant. A write hit leaves the line modified.
- R8: At most one `bus_grant` bit is set at any time. Simultaneous requests are served in the order processor 1, 2, 3. A read command is `bus_cmd`=1.
- R9: While any cache holds the line exclusive or modified, no other cache holds a valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | NCPU | Per-processor request, held until done |
| cpu_wr | input | NCPU | Request is a write when 1 |
| cpu_wdata | input | NCPU*DW | Write data, processor k in slice k-1 |
| cpu_done | output | NCPU | One-cycle completion pulse per processor |
| cpu_rdata | output | NCPU*DW | Value read or written, valid with done |
| line_state | output | 2*NCPU | Per-cache coherence state code |
| bus_grant | output | NCPU | Current bus owner, one-hot or zero |
| bus_cmd | output | 2 | Command in address phase: 0 none, 1 read, 2 read-invalidate, 3 invalidate |
| bus_shared | output | 1 | A snooper holds a valid copy |
| bus_wait | output | 1 | A snooper holds the line modified and will write it back |
| bus_wb | output | 1 | Write-back phase, owner data goes to memory |
| mem_data | output | DW | Main-memory word |

## Verification
The hardest situation to reach from the ports is two requests arriving in the same cycle when the later one depends on the earlier. The bench raises a shared-line write on processor 1 and a read miss on processor 3 in the same cycle. Processor 1 must invalidate first and become the modified owner. Processor 3's read must then stall on that new owner and see the write-back. The scoreboard queue holds the expected completions in priority order, so a swapped order or a missed write-back shows up as a data or state mismatch. A second reset then produces an exclusive line, which is the only way to exercise a silent exclusive-to-modified upgrade followed by a write miss against a modified owner.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    // Coherence state of one cached line (codes visible on line_state).
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    // Command broadcast in the address phase.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_INV  = 2'd3
    } bus_cmd_e;

    // Phase of the shared bus.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_WB   = 2'd2,
        PH_DONE = 2'd3
    } bus_ph_e;

    // Bus command a local access needs, given the current line state.
    function automatic bus_cmd_e need_cmd(input logic is_write, input line_st_e st);
        if (!is_write)
            return (st == ST_I) ? CMD_RD : CMD_NONE;
        case (st)
            ST_I:    return CMD_RDX;
            ST_S:    return CMD_INV;
            default: return CMD_NONE;
        endcase
    endfunction

    // State a snooping cache takes at the end of an address phase.
    // A modified owner keeps its state until its write-back phase.
    function automatic line_st_e snoop_next(input bus_cmd_e cmd, input line_st_e st);
        case (cmd)
            CMD_RD:  return (st == ST_E) ? ST_S : st;
            CMD_RDX: return (st == ST_M) ? ST_M : ST_I;
            CMD_INV: return ST_I;
            default: return st;
        endcase
    endfunction

endpackage

// File: rtl/mesi_arbiter.sv
module mesi_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Fixed priority: index 0 (processor 1) is highest.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesi_bus_ctrl.sv
module mesi_bus_ctrl
    import mesi_pkg::*;
#(
    parameter int N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic [N-1:0][1:0] req_cmd,
    input  logic [N-1:0]     snoop_shared,
    input  logic [N-1:0]     snoop_owner,
    output bus_ph_e          phase,
    output logic [N-1:0]     grant_q,
    output bus_cmd_e         cmd_q,
    output logic             shared_q,
    output logic [N-1:0]     owner_q
);
    logic [N-1:0] gnt;
    bus_cmd_e     cmd_sel;

    mesi_arbiter #(.N(N)) arb_i (
        .req (req),
        .gnt (gnt)
    );

    always_comb begin
        cmd_sel = CMD_NONE;
        for (int i = 0; i < N; i++)
            if (gnt[i]) cmd_sel = bus_cmd_e'(req_cmd[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            grant_q  <= '0;
            cmd_q    <= CMD_NONE;
            shared_q <= 1'b0;
            owner_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (|req) begin
                        grant_q <= gnt;
                        cmd_q   <= cmd_sel;
                        phase   <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    shared_q <= |snoop_shared;
                    owner_q  <= snoop_owner;
                    phase    <= (|snoop_owner) ? PH_WB : PH_DONE;
                end
                PH_WB: begin
                    phase <= PH_DONE;
                end
                default: begin
                    owner_q <= '0;
                    phase   <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mesi_node.sv
module mesi_node
    import mesi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    input  bus_ph_e       phase,
    input  logic          granted,
    input  bus_cmd_e      cmd,
    input  logic          shared_seen,
    input  logic          wb_owner,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output bus_cmd_e      bus_cmd_req,
    output logic          snoop_shared,
    output logic          snoop_owner,
    output line_st_e      state,
    output logic [DW-1:0] line_data,
    output logic          done,
    output logic [DW-1:0] rd_data
);
    line_st_e      state_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdata_q;
    logic          done_q;
    logic          active;
    logic          hit_go;

    always_comb begin
        bus_cmd_req  = need_cmd(req_write, state_q);
        active       = req_valid && !done_q;
        bus_req      = active && (bus_cmd_req != CMD_NONE);
        hit_go       = active && (bus_cmd_req == CMD_NONE) && (phase == PH_IDLE);
        snoop_shared = (phase == PH_ADDR) && !granted && (state_q != ST_I);
        snoop_owner  = (phase == PH_ADDR) && !granted && (state_q == ST_M);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_I;
            data_q  <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (hit_go) begin
                done_q <= 1'b1;
                if (req_write) begin
                    state_q <= ST_M;
                    data_q  <= req_wdata;
                    rdata_q <= req_wdata;
                end else begin
                    rdata_q <= data_q;
                end
            end else if (phase == PH_ADDR && !granted) begin
                state_q <= snoop_next(cmd, state_q);
            end else if (phase == PH_WB && wb_owner) begin
                state_q <= (cmd == CMD_RD) ? ST_S : ST_I;
            end else if (phase == PH_DONE && granted) begin
                done_q <= 1'b1;
                if (cmd == CMD_RD) begin
                    state_q <= shared_seen ? ST_S : ST_E;
                    data_q  <= mem_rdata;
                    rdata_q <= mem_rdata;
                end else begin
                    state_q <= ST_M;
                    data_q  <= req_wdata;
                    rdata_q <= req_wdata;
                end
            end
        end
    end

    assign state     = state_q;
    assign line_data = data_q;
    assign done      = done_q;
    assign rd_data   = rdata_q;
endmodule

// File: rtl/mesi_coherence_top.sv
module mesi_coherence_top
    import mesi_pkg::*;
#(
    parameter int          NCPU     = 3,
    parameter int          DW       = 8,
    parameter logic [DW-1:0] MEM_INIT = 8'h2A
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCPU-1:0]      cpu_req,
    input  logic [NCPU-1:0]      cpu_wr,
    input  logic [NCPU*DW-1:0]   cpu_wdata,
    output logic [NCPU-1:0]      cpu_done,
    output logic [NCPU*DW-1:0]   cpu_rdata,
    output logic [2*NCPU-1:0]    line_state,
    output logic [NCPU-1:0]      bus_grant,
    output logic [1:0]           bus_cmd,
    output logic                 bus_shared,
    output logic                 bus_wait,
    output logic                 bus_wb,
    output logic [DW-1:0]        mem_data
);
    bus_ph_e             phase;
    logic [NCPU-1:0]     grant_q;
    bus_cmd_e            cmd_q;
    logic                shared_q;
    logic [NCPU-1:0]     owner_q;
    logic [NCPU-1:0]     node_req;
    logic [NCPU-1:0][1:0] node_cmd;
    logic [NCPU-1:0]     snp_shared;
    logic [NCPU-1:0]     snp_owner;
    line_st_e            node_st   [NCPU];
    logic [DW-1:0]       node_data [NCPU];
    logic [DW-1:0]       node_rd   [NCPU];
    bus_cmd_e            node_cmd_e[NCPU];
    logic [DW-1:0]       mem_q;
    logic [DW-1:0]       wb_data;

    mesi_bus_ctrl #(.N(NCPU)) bus_i (
        .clk          (clk),
        .rst          (rst),
        .req          (node_req),
        .req_cmd      (node_cmd),
        .snoop_shared (snp_shared),
        .snoop_owner  (snp_owner),
        .phase        (phase),
        .grant_q      (grant_q),
        .cmd_q        (cmd_q),
        .shared_q     (shared_q),
        .owner_q      (owner_q)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_node
        mesi_node #(.DW(DW)) node_i (
            .clk          (clk),
            .rst          (rst),
            .req_valid    (cpu_req[g]),
            .req_write    (cpu_wr[g]),
            .req_wdata    (cpu_wdata[g*DW +: DW]),
            .phase        (phase),
            .granted      (grant_q[g]),
            .cmd          (cmd_q),
            .shared_seen  (shared_q),
            .wb_owner     (owner_q[g]),
            .mem_rdata    (mem_q),
            .bus_req      (node_req[g]),
            .bus_cmd_req  (node_cmd_e[g]),
            .snoop_shared (snp_shared[g]),
            .snoop_owner  (snp_owner[g]),
            .state        (node_st[g]),
            .line_data    (node_data[g]),
            .done         (cpu_done[g]),
            .rd_data      (node_rd[g])
        );
        assign node_cmd[g]               = node_cmd_e[g];
        assign line_state[2*g +: 2]      = node_st[g];
        assign cpu_rdata[g*DW +: DW]     = node_rd[g];
    end

    // Data the write-back owner places on the bus.
    always_comb begin
        wb_data = '0;
        for (int i = 0; i < NCPU; i++)
            if (owner_q[i]) wb_data = wb_data | node_data[i];
    end

    // Main-memory word: updated only by a write-back phase.
    always_ff @(posedge clk) begin
        if (rst)
            mem_q <= MEM_INIT;
        else if (phase == PH_WB)
            mem_q <= wb_data;
    end

    always_comb begin
        bus_grant  = (phase != PH_IDLE) ? grant_q : '0;
        bus_cmd    = (phase == PH_ADDR) ? cmd_q : CMD_NONE;
        bus_shared = |snp_shared;
        bus_wait   = |snp_owner;
        bus_wb     = (phase == PH_WB);
        mem_data   = mem_q;
    end
endmodule

// File: rtl/mesi_coherence_checker.sv
module mesi_coherence_checker
    import mesi_pkg::*;
#(
    parameter int N = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [2*N-1:0]    line_state,
    input logic [N-1:0]      bus_grant,
    input logic [1:0]        bus_cmd,
    input logic              bus_wait,
    input logic              bus_wb
);
    logic [N-1:0] valid;

    always_comb
        for (int i = 0; i < N; i++)
            valid[i] = (line_state[2*i +: 2] != 2'd0);

    // R8: a single bus owner at a time
    a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_grant));

    // R5: a wait always leads to a write-back phase next cycle
    a_r5_wait_then_wb: assert property (@(posedge clk) disable iff (rst)
        bus_wait |=> bus_wb);

    // R4: after an invalidate only the granted cache may keep a copy
    a_r4_inv_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'd3) |=> ((valid & ~$past(bus_grant)) == '0));

    // R9: exclusive or modified copies are the only valid copy
    for (genvar g = 0; g < N; g++) begin : g_own
        a_r9_single_owner: assert property (@(posedge clk) disable iff (rst)
            (line_state[2*g +: 2] >= 2'd2) |-> ($countones(valid) == 1));
    end
endmodule

bind mesi_coherence_top mesi_coherence_checker #(.N(NCPU)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .line_state (line_state),
    .bus_grant  (bus_grant),
    .bus_cmd    (bus_cmd),
    .bus_wait   (bus_wait),
    .bus_wb     (bus_wb)
);

// File: tb/mesi_coherence_top_tb_top.sv
module mesi_coherence_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int DW = 8;
    localparam logic [7:0] INIT = 8'h2A;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      cpu_req = '0;
    logic [N-1:0]      cpu_wr = '0;
    logic [N*DW-1:0]   cpu_wdata = '0;
    logic [N-1:0]      cpu_done;
    logic [N*DW-1:0]   cpu_rdata;
    logic [2*N-1:0]    line_state;
    logic [N-1:0]      bus_grant;
    logic [1:0]        bus_cmd;
    logic              bus_shared, bus_wait, bus_wb;
    logic [DW-1:0]     mem_data;

    mesi_coherence_top #(.NCPU(N), .DW(DW), .MEM_INIT(INIT)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .line_state(line_state), .bus_grant(bus_grant), .bus_cmd(bus_cmd),
        .bus_shared(bus_shared), .bus_wait(bus_wait), .bus_wb(bus_wb),
        .mem_data(mem_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int         cpu;
        logic [7:0] data;
        logic [1:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   grant_cyc = 0;
    int   wait_cyc  = 0;
    int   wb_cyc    = 0;
    int   inv_cyc   = 0;
    int   rdx_cyc   = 0;
    int   shr_cyc   = 0;
    int   cycles    = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] st_of(input int cpu);
        return line_state[2*cpu +: 2];
    endfunction

    // Bus activity counters, sampled away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (|bus_grant) grant_cyc++;
            if (bus_wait) wait_cyc++;
            if (bus_wb) wb_cyc++;
            if (bus_cmd == 2'd3) inv_cyc++;
            if (bus_cmd == 2'd2) rdx_cyc++;
            if (bus_shared && bus_cmd == 2'd1) shr_cyc++;
        end
    end

    // Scoreboard monitor: each completion pops the oldest expected item.
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst && cpu_done[i]) begin
                if (q.size() == 0) begin
                    check(0, "R8 unexpected completion", i, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.cpu == i, {e.tag, " completion order"}, i, e.cpu);
                    check(cpu_rdata[i*DW +: DW] == e.data, {e.tag, " data"},
                          cpu_rdata[i*DW +: DW], e.data);
                    check(st_of(i) == e.st, {e.tag, " state"}, st_of(i), e.st);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input int cpu, input logic [7:0] d, input logic [1:0] s, input string tag);
        exp_t e;
        e.cpu = cpu; e.data = d; e.st = s; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: push expected item, raise request, hold until done.
    task automatic run_op(input int cpu, input logic wr, input logic [7:0] wd,
                          input logic [7:0] exp_d, input logic [1:0] exp_s, input string tag);
        int t;
        push(cpu, exp_d, exp_s, tag);
        @(negedge clk);
        cpu_wr[cpu] = wr;
        cpu_wdata[cpu*DW +: DW] = wd;
        cpu_req[cpu] = 1'b1;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!cpu_done[cpu] && t < 100);
        cpu_req[cpu] = 1'b0;
        if (t >= 100) check(0, {tag, " timeout"}, t, 0);
        @(negedge clk);
    endtask

    initial begin
        int g0;
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(line_state == '0, "R1 states", line_state, 0);
        check(mem_data == INIT, "R1 memory", mem_data, INIT);
        check(bus_grant == '0 && bus_cmd == 2'd0, "R1 bus idle", {bus_grant, bus_cmd}, 0);
        check(cpu_done == '0, "R1 done", cpu_done, 0);

        // Replay: P1 read, P2 read, P2 write 120, P3 read
        run_op(0, 0, 8'h00, INIT, 2'd2, "R2 read miss exclusive");
        check(st_of(1) == 0 && st_of(2) == 0, "R2 others invalid", line_state, 2);
        run_op(1, 0, 8'h00, INIT, 2'd1, "R3 second reader shared");
        check(st_of(0) == 2'd1, "R3 first copy shared", st_of(0), 1);
        check(shr_cyc == 1, "R3 shared response", shr_cyc, 1);
        run_op(1, 1, 8'd120, 8'd120, 2'd3, "R4 write shared");
        check(inv_cyc == 1, "R4 invalidate issued", inv_cyc, 1);
        check(st_of(0) == 2'd0, "R4 other copy invalid", st_of(0), 0);
        run_op(2, 0, 8'h00, 8'd120, 2'd1, "R5 read of modified");
        check(wait_cyc == 1 && wb_cyc == 1, "R5 wait and write-back", {wait_cyc[3:0], wb_cyc[3:0]}, 8'h11);
        check(mem_data == 8'd120, "R5 memory updated", mem_data, 120);
        check(line_state == 6'b01_01_00, "R5 final states I,S,S", line_state, 6'b01_01_00);

        // Write miss against a modified owner
        run_op(2, 1, 8'h55, 8'h55, 2'd3, "R4 write shared P3");
        run_op(0, 1, 8'h66, 8'h66, 2'd3, "R6 write miss");
        check(rdx_cyc == 1, "R6 read-invalidate issued", rdx_cyc, 1);
        check(mem_data == 8'h55, "R6 owner wrote back", mem_data, 8'h55);
        check(st_of(2) == 2'd0, "R6 owner invalid", st_of(2), 0);

        // Hits on a modified line need no bus
        g0 = grant_cyc;
        run_op(0, 1, 8'h77, 8'h77, 2'd3, "R7 write hit modified");
        run_op(0, 0, 8'h00, 8'h77, 2'd3, "R7 read hit");
        check(grant_cyc == g0, "R7 no bus grant on hits", grant_cyc - g0, 0);
        check(mem_data == 8'h55, "R7 memory untouched", mem_data, 8'h55);

        run_op(1, 0, 8'h00, 8'h77, 2'd1, "R5 read of modified P2");
        check(st_of(0) == 2'd1 && mem_data == 8'h77, "R5 owner shared, memory", {st_of(0), mem_data}, {2'd1, 8'h77});

        // R8: simultaneous requests, P1 write (shared) before P3 read
        push(0, 8'h11, 2'd3, "R8 first served P1");
        push(2, 8'h11, 2'd1, "R8 second served P3");
        @(negedge clk);
        cpu_wr[0] = 1'b1; cpu_wdata[0 +: DW] = 8'h11; cpu_req[0] = 1'b1;
        cpu_wr[2] = 1'b0; cpu_req[2] = 1'b1;
        for (int t = 0; t < 100 && cpu_req != '0; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if (cpu_done[i]) cpu_req[i] = 1'b0;
        end
        check(cpu_req == '0, "R8 both served", cpu_req, 0);
        @(negedge clk);
        check(line_state == 6'b01_00_01, "R8 final states S,I,S", line_state, 6'b01_00_01);
        check(mem_data == 8'h11, "R8 memory", mem_data, 8'h11);

        // Second reset: exclusive line, silent upgrade, then write miss
        do_reset();
        check(mem_data == INIT && line_state == '0, "R1 reset again", mem_data, INIT);
        run_op(2, 0, 8'h00, INIT, 2'd2, "R2 read miss exclusive P3");
        g0 = grant_cyc;
        run_op(2, 1, 8'h44, 8'h44, 2'd3, "R7 write hit exclusive");
        check(grant_cyc == g0, "R7 no bus on exclusive upgrade", grant_cyc - g0, 0);
        run_op(0, 1, 8'h99, 8'h99, 2'd3, "R6 write miss P1");
        check(mem_data == 8'h44 && st_of(2) == 2'd0, "R6 write-back then invalid",
              {st_of(2), mem_data}, {2'd0, 8'h44});
        check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule